// File: doc/BRIEF.md
# Transmit Word Queue with Underrun Repeat

This block holds outgoing audio words for a time-slotted serial port. Software-side writes push 16-bit words into a small circular store. The serial shifter asks for one word each time it finishes sending the previous one, and the block hands that word back on a registered output in the next cycle.

There is no count register and no extra pointer bit. Fullness is worked out from whether the two pointers match, together with a single flag that records whether the most recent access was a store. When the shifter asks for a word and the store holds none, the block sends the word it sent last time again instead of stale data. It then latches a sticky underrun flag, and that flag holds back the data-request interrupt until software clears it. A store into a full queue is not blocked: it overwrites the oldest unsent word.

Top module: `txf_audio_tx_fifo`

## Requirements
- R1: After reset the queue reports empty and not full, the underrun flag is 0, `pullData` is 0, and every storage slot holds 0.
- R2: Words are delivered in the order they were written. `pullData` takes the new word in the clock edge that ends the cycle in which `pullReq` is high, so it is visible in the cycle after the request.
- R3: After 16 writes with no pulls, starting from empty, `fifoFull` is 1 and `fifoEmpty` is 0.
- R4: Once every written word has been pulled, `fifoEmpty` is 1 and `fifoFull` is 0.
- R5: A pull while empty is an underrun. It delivers the previously delivered word again, which is the slot one behind the read position, modulo 16. The queue stays empty and the underrun flag becomes 1.
- R6: The underrun flag stays at 1 until a cycle with `underrunClr` high. If an underrun and a clear happen in the same cycle, the flag ends at 1.
- R7: `irqReq` is 1 exactly when `irqEnable` is 1, the queue is not full and the underrun flag is 0.
- R8: A write while full, with no pull in the same cycle, overwrites the oldest unsent word and advances the write position. Afterwards the queue shows neither full nor empty, the next pull returns the overrunning word, and the queue is then empty.
- R9: A write and a pull in the same cycle are both carried out, and the cycle counts as a write access. When full, the pull returns the oldest word and the queue stays full. When empty, the pull is an underrun repeat and the written word remains queued.
- R10: An underrun before any word has been written after reset delivers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Store `wrData` into the queue this cycle |
| wrData | input | 16 | Word to store |
| pullReq | input | 1 | Shifter finished a word and takes the next |
| pullData | output | 16 | Word handed to the shifter, registered |
| underrunClr | input | 1 | Clears the sticky underrun flag |
| irqEnable | input | 1 | Allows the data-request interrupt |
| fifoFull | output | 1 | Pointers equal and last access was a write |
| fifoEmpty | output | 1 | Pointers equal and last access was a pull |
| underrunFlag | output | 1 | Sticky underrun status |
| irqReq | output | 1 | Level data-request interrupt |

## Verification
The hardest states to reach from the ports are the ones where the access-type flag decides the outcome while the pointers are equal: a write and a pull in the same cycle, both on a full queue and on an empty one, and an overrun write that quietly turns a full queue into one that looks like it holds a single word. The directed tasks get there by filling the queue with exactly 16 words, then adding one more write or a simultaneous write and pull. They then drain it and compare each delivered word against a model of the slot positions. Underrun repeats are provoked both after a drain and right after a fresh reset, where the slot behind the read position still holds its reset value.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef struct packed {
    logic storeWord;   // write wrData at write pointer
    logic takeWord;    // normal pull at read pointer
    logic repeatWord;  // underrun pull, slot behind read pointer
  } fifoStrobe_t;
endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   pullReq,
  input  logic                   underrunClr,
  input  logic                   irqEnable,
  output txf_pkg::fifoStrobe_t   strobe,
  output logic [PTR_W-1:0]       wrPtr,
  output logic [PTR_W-1:0]       rdPtr,
  output logic                   fifoFull,
  output logic                   fifoEmpty,
  output logic                   underrunFlag,
  output logic                   irqReq
);
  logic lastWasWrite;
  logic ptrMatch;
  logic underrunPull;

  assign ptrMatch     = (wrPtr == rdPtr);
  assign fifoFull     = ptrMatch & lastWasWrite;
  assign fifoEmpty    = ptrMatch & ~lastWasWrite;
  assign underrunPull = pullReq & fifoEmpty;

  assign strobe.storeWord  = wrEn;
  assign strobe.takeWord   = pullReq & ~fifoEmpty;
  assign strobe.repeatWord = underrunPull;

  // Underrun pull steps back one and re-advances: net pointer unchanged.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strobe.takeWord)  rdPtr <= rdPtr + PTR_W'(1);
      if (strobe.storeWord) wrPtr <= wrPtr + PTR_W'(1);
    end
  end

  // A cycle with a write counts as a write access, even with a pull.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastWasWrite <= 1'b0;
    else if (wrEn)    lastWasWrite <= 1'b1;
    else if (pullReq) lastWasWrite <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             underrunFlag <= 1'b0;
    else if (underrunPull) underrunFlag <= 1'b1;
    else if (underrunClr)  underrunFlag <= 1'b0;
  end

  assign irqReq = irqEnable & ~fifoFull & ~underrunFlag;
endmodule

// File: rtl/txf_datapath.sv
module txf_datapath #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txf_pkg::fifoStrobe_t strobe,
  input  logic [PTR_W-1:0]     wrPtr,
  input  logic [PTR_W-1:0]     rdPtr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    pullData
);
  logic [DATA_W-1:0] slotMem [DEPTH];
  logic [PTR_W-1:0]  prevPtr;
  logic [PTR_W-1:0]  readAddr;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotMem[g] <= '0;
      else if (strobe.storeWord && (wrPtr == PTR_W'(g)))
        slotMem[g] <= wrData;
    end
  end

  assign prevPtr  = rdPtr - PTR_W'(1);
  assign readAddr = strobe.repeatWord ? prevPtr : rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pullData <= '0;
    else if (strobe.takeWord || strobe.repeatWord)
      pullData <= slotMem[readAddr];
  end
endmodule

// File: rtl/txf_audio_tx_fifo.sv
module txf_audio_tx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pullReq,
  output logic [DATA_W-1:0] pullData,
  input  logic              underrunClr,
  input  logic              irqEnable,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              underrunFlag,
  output logic              irqReq
);
  txf_pkg::fifoStrobe_t strobe;
  logic [PTR_W-1:0]     wrPtr;
  logic [PTR_W-1:0]     rdPtr;

  txf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .pullReq(pullReq),
    .underrunClr(underrunClr), .irqEnable(irqEnable),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .underrunFlag(underrunFlag), .irqReq(irqReq)
  );

  txf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .wrData(wrData), .pullData(pullData)
  );
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              pullReq,
  input logic              underrunClr,
  input logic              irqEnable,
  input logic [DATA_W-1:0] pullData,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              underrunFlag,
  input logic              irqReq
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  assert_underrun_repeat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pullReq && fifoEmpty) |=> (pullData == $past(pullData)) && underrunFlag);

  assert_underrun_stays_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pullReq && fifoEmpty && !wrEn) |=> fifoEmpty);

  assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !underrunClr) |=> underrunFlag);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull || underrunFlag || !irqEnable) |-> !irqReq);

  assert_overrun_unblocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrEn && !pullReq) |=> (!fifoFull && !fifoEmpty));

  assert_full_stays_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrEn && pullReq) |=> fifoFull);
endmodule

bind txf_audio_tx_fifo txf_checker #(.DATA_W(DATA_W)) u_txf_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .pullReq(pullReq),
  .underrunClr(underrunClr), .irqEnable(irqEnable), .pullData(pullData),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .underrunFlag(underrunFlag), .irqReq(irqReq)
);

// File: tb/txf_audio_tx_fifo_bench.sv
module txf_audio_tx_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        pullReq = 1'b0;
  logic [15:0] pullData;
  logic        underrunClr = 1'b0;
  logic        irqEnable = 1'b0;
  logic        fifoFull, fifoEmpty, underrunFlag, irqReq;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  txf_audio_tx_fifo u_txf_audio_tx_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .pullReq(pullReq), .pullData(pullData), .underrunClr(underrunClr),
    .irqEnable(irqEnable), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .underrunFlag(underrunFlag), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doPull();
    pullReq = 1'b1;
    @(negedge clk); pullReq = 1'b0;
  endtask

  task automatic doBoth(input logic [15:0] d);
    wrEn = 1'b1; wrData = d; pullReq = 1'b1;
    @(negedge clk); wrEn = 1'b0; pullReq = 1'b0;
  endtask

  task automatic doClear();
    underrunClr = 1'b1;
    @(negedge clk); underrunClr = 1'b0;
  endtask

  task automatic testReset();
    check("R1 empty", fifoEmpty, 1);
    check("R1 full", fifoFull, 0);
    check("R1 underrun", underrunFlag, 0);
    check("R1 data", pullData, 0);
    check("R7 irq disabled", irqReq, 0);
  endtask

  task automatic testOrder();
    doWrite(16'hA001); doWrite(16'hA002); doWrite(16'hA003);
    check("R2 not empty", fifoEmpty, 0);
    for (int i = 1; i <= 3; i++) begin
      doPull();
      check("R2 order", pullData, 32'hA000 + i);
    end
    check("R4 drained empty", fifoEmpty, 1);
    check("R4 drained not full", fifoFull, 0);
    check("R2 no underrun", underrunFlag, 0);
  endtask

  task automatic testFull();
    irqEnable = 1'b1;
    #1 check("R7 irq enabled", irqReq, 1);
    for (int i = 0; i < 16; i++) doWrite(16'hB000 + 16'(i));
    check("R3 full", fifoFull, 1);
    check("R3 not empty", fifoEmpty, 0);
    check("R7 irq low when full", irqReq, 0);
    for (int i = 0; i < 16; i++) begin
      doPull();
      check("R2 full drain order", pullData, 32'hB000 + i);
    end
    check("R4 empty after full drain", fifoEmpty, 1);
  endtask

  task automatic testUnderrun();
    doPull();
    check("R5 repeat word", pullData, 32'hB00F);
    check("R5 stays empty", fifoEmpty, 1);
    check("R5 flag set", underrunFlag, 1);
    check("R7 irq held off", irqReq, 0);
    doPull();
    check("R5 second repeat", pullData, 32'hB00F);
    @(negedge clk);
    check("R6 sticky", underrunFlag, 1);
    doClear();
    check("R6 cleared", underrunFlag, 0);
    check("R7 irq back", irqReq, 1);
    underrunClr = 1'b1; pullReq = 1'b1;
    @(negedge clk); underrunClr = 1'b0; pullReq = 1'b0;
    check("R6 set wins over clear", underrunFlag, 1);
    doClear();
  endtask

  task automatic testOverrun();
    for (int i = 0; i < 16; i++) doWrite(16'hC000 + 16'(i));
    check("R8 full before overrun", fifoFull, 1);
    doWrite(16'hC010);
    check("R8 not full after overrun", fifoFull, 0);
    check("R8 not empty after overrun", fifoEmpty, 0);
    doPull();
    check("R8 overrun word", pullData, 32'hC010);
    check("R8 empty after", fifoEmpty, 1);
    check("R8 no underrun", underrunFlag, 0);
  endtask

  task automatic testSimultaneous();
    doBoth(16'hD000);
    check("R9 empty both repeats", pullData, 32'hC010);
    check("R9 empty both underrun", underrunFlag, 1);
    check("R9 word kept", fifoEmpty, 0);
    check("R9 not full", fifoFull, 0);
    doPull();
    check("R9 queued word", pullData, 32'hD000);
    check("R9 empty again", fifoEmpty, 1);
    doClear();
    for (int i = 0; i < 16; i++) doWrite(16'hE000 + 16'(i));
    doBoth(16'hE010);
    check("R9 full both oldest", pullData, 32'hE000);
    check("R9 full stays full", fifoFull, 1);
    for (int i = 1; i <= 16; i++) begin
      doPull();
      check("R9 drain after both", pullData, 32'hE000 + i);
    end
    check("R9 drained", fifoEmpty, 1);
  endtask

  task automatic testResetUnderrun();
    doReset();
    check("R1 empty after reset", fifoEmpty, 1);
    doPull();
    check("R10 reset slot zero", pullData, 0);
    check("R10 underrun flag", underrunFlag, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrder();
    testFull();
    testUnderrun();
    testOverrun();
    testSimultaneous();
    testResetUnderrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule